// File: doc/BRIEF.md
# Line Voltage Residual Classifier

This block watches the three line voltages of a three-level inverter and sorts a single-switch open-circuit fault into a group. Each sample gives, for the AB, BC and CA lines, the measured voltage and the voltage the present switch commands should produce, both as signed fixed-point values, plus the DC bus voltage. The block forms each line's residual (measured minus commanded). It compares the residual with a threshold of roughly a tenth of the bus voltage and reduces each line to a ternary code of +1, 0 or -1.

The three codes form a signature. The signature is matched against a fixed table. An all-zero signature means healthy operation. Six nonzero signatures each name a faulted phase and whether the failed switch carries an odd or an even number. Any other nonzero signature is reported as an unrecognised fault. A reported result changes only when the same signature arrives on two valid samples in a row, so a single noisy sample cannot move it. The surrounding controller uses the group to pick a fault-tolerant switching scheme and to finish locating the fault.

Top module: `line_resid_classifier`

## Requirements
- R1: For each line, the code is +1 (encoded 2'b01) when the residual is strictly above the threshold, -1 (encoded 2'b11) when it is strictly below the negated threshold, and 0 (2'b00) otherwise. A residual equal to ±threshold gives 0.
- R2: The threshold is floor(busV × 26 / 256), recomputed from the bus voltage of each sample.
- R3: `sigCode` carries the signature of the latest valid sample in the cycle after that sample: AB in bits [5:4], BC in [3:2], CA in [1:0].
- R4: A confirmed signature (AB,BC,CA) sets `groupValid` with `groupPhase` 0=A, 1=B, 2=C and `groupEven` as follows. (-1,0,+1) gives A odd. (+1,0,-1) gives A even. (+1,-1,0) gives B odd. (-1,+1,0) gives B even. (0,+1,+1) gives C odd. (0,-1,-1) gives C even.
- R5: A confirmed all-zero signature sets `healthy` and clears `groupValid` and `unknownFault`.
- R6: A confirmed nonzero signature that is not in the R4 table sets `unknownFault`, with `groupValid` low.
- R7: A signature is confirmed only when two consecutive valid samples carry it. Cycles with the strobe low between those samples do not break the pair. An unconfirmed sample leaves the reported result unchanged.
- R8: While `sampleValid` is low, every output holds its value, whatever the voltage inputs do.
- R9: After reset, `healthy` is 1, `groupValid` and `unknownFault` are 0, and `sigCode` is 0.
- R10: Exactly one of `healthy`, `groupValid` and `unknownFault` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Qualifies the voltage inputs for one cycle |
| measAb | input | VW | Measured AB line voltage, signed |
| measBc | input | VW | Measured BC line voltage, signed |
| measCa | input | VW | Measured CA line voltage, signed |
| cmdAb | input | VW | Commanded AB line voltage, signed |
| cmdBc | input | VW | Commanded BC line voltage, signed |
| cmdCa | input | VW | Commanded CA line voltage, signed |
| busV | input | UW | DC bus voltage, unsigned |
| sigCode | output | 6 | Signature of the latest valid sample |
| healthy | output | 1 | Confirmed all-zero signature |
| groupValid | output | 1 | Confirmed signature names a fault group |
| groupPhase | output | 2 | Faulted phase: 0=A, 1=B, 2=C |
| groupEven | output | 1 | Faulted switch number is even |
| unknownFault | output | 1 | Confirmed signature not in the table |

## Verification
On every cycle the assertions check several properties. Exactly one result flag is up. Outputs stay still while no sample is offered. The reported result moves only after a valid sample whose signature repeats the previous one. The phase code never takes its unused value. The threshold also stays between one sixteenth and one eighth of the bus voltage. Only the directed scenarios can show the exact ternary decision at the ±threshold boundary, the bit placement of each signature, and the mapping of each of the six signatures to its phase and parity. They also show that an isolated or alternating signature leaves the report alone.

// File: rtl/resid_pkg.sv
package resid_pkg;

  localparam logic [1:0] TERN_ZERO = 2'b00;
  localparam logic [1:0] TERN_POS  = 2'b01;
  localparam logic [1:0] TERN_NEG  = 2'b11;

  localparam int LINES  = 3;
  localparam int SIG_W  = 2 * LINES;

  typedef enum logic [1:0] {
    PH_A    = 2'd0,
    PH_B    = 2'd1,
    PH_C    = 2'd2,
    PH_NONE = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPrev;
  } dp_strobe_t;

  // (AB,BC,CA) signatures of the six fault groups
  localparam logic [SIG_W-1:0] SIG_A_ODD  = {TERN_NEG,  TERN_ZERO, TERN_POS};
  localparam logic [SIG_W-1:0] SIG_A_EVEN = {TERN_POS,  TERN_ZERO, TERN_NEG};
  localparam logic [SIG_W-1:0] SIG_B_ODD  = {TERN_POS,  TERN_NEG,  TERN_ZERO};
  localparam logic [SIG_W-1:0] SIG_B_EVEN = {TERN_NEG,  TERN_POS,  TERN_ZERO};
  localparam logic [SIG_W-1:0] SIG_C_ODD  = {TERN_ZERO, TERN_POS,  TERN_POS};
  localparam logic [SIG_W-1:0] SIG_C_EVEN = {TERN_ZERO, TERN_NEG,  TERN_NEG};

endpackage

// File: rtl/resid_datapath.sv
module resid_datapath
  import resid_pkg::*;
#(
  parameter int VW       = 16,
  parameter int UW       = 16,
  parameter int TH_MUL   = 26,
  parameter int TH_SHIFT = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [LINES-1:0][VW-1:0]    measV,
  input  logic [LINES-1:0][VW-1:0]    cmdV,
  input  logic [UW-1:0]               busV,
  input  dp_strobe_t                  strobe,
  output logic [SIG_W-1:0]            sigNow,
  output logic [SIG_W-1:0]            prevSig
);

  localparam int RW = VW + 1;
  localparam int PW = UW + $clog2(TH_MUL + 1);
  localparam int TW = PW - TH_SHIFT;
  localparam int CW = ((RW > TW) ? RW : TW) + 1;

  logic [PW-1:0]        prod;
  logic [TW-1:0]        thresh;
  logic signed [CW-1:0] threshPos;
  logic signed [CW-1:0] threshNeg;

  assign prod      = PW'(busV) * PW'(TH_MUL);
  assign thresh    = TW'(prod >> TH_SHIFT);
  assign threshPos = $signed({{(CW-TW){1'b0}}, thresh});
  assign threshNeg = -threshPos;

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic signed [RW-1:0] resid;
    logic signed [CW-1:0] residExt;
    logic [1:0]           code;

    assign resid    = $signed({measV[g][VW-1], measV[g]}) - $signed({cmdV[g][VW-1], cmdV[g]});
    assign residExt = {{(CW-RW){resid[RW-1]}}, resid};

    always_comb begin
      if (residExt > threshPos)      code = TERN_POS;
      else if (residExt < threshNeg) code = TERN_NEG;
      else                           code = TERN_ZERO;
    end

    assign sigNow[2*g +: 2] = code;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                prevSig <= '0;
    else if (strobe.loadPrev) prevSig <= sigNow;
  end

  if (TH_MUL == 26 && TH_SHIFT == 8) begin : gThreshChk
    // R2
    th_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
      UW'(thresh) <= (busV >> 3));
    // R2
    th_lower_chk: assert property (@(posedge clk) disable iff (!rstN)
      UW'(thresh) >= (busV >> 4));
  end

endmodule

// File: rtl/resid_control.sv
module resid_control
  import resid_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [SIG_W-1:0] sigNow,
  input  logic [SIG_W-1:0] prevSig,
  output dp_strobe_t       strobe,
  output logic [SIG_W-1:0] sigCode,
  output logic             healthy,
  output logic             groupValid,
  output logic [1:0]       groupPhase,
  output logic             groupEven,
  output logic             unknownFault
);

  logic   havePrev;
  logic   confirm;
  logic   decHealthy, decGroup, decEven, decUnknown;
  phase_e decPhase;

  assign strobe.loadPrev = sampleValid;
  assign confirm         = sampleValid && havePrev && (sigNow == prevSig);

  always_comb begin
    decHealthy = 1'b0;
    decGroup   = 1'b1;
    decUnknown = 1'b0;
    decPhase   = PH_NONE;
    decEven    = 1'b0;
    unique case (sigNow)
      '0:         begin decHealthy = 1'b1; decGroup = 1'b0; end
      SIG_A_ODD:  decPhase = PH_A;
      SIG_A_EVEN: begin decPhase = PH_A; decEven = 1'b1; end
      SIG_B_ODD:  decPhase = PH_B;
      SIG_B_EVEN: begin decPhase = PH_B; decEven = 1'b1; end
      SIG_C_ODD:  decPhase = PH_C;
      SIG_C_EVEN: begin decPhase = PH_C; decEven = 1'b1; end
      default:    begin decGroup = 1'b0; decUnknown = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      havePrev     <= 1'b0;
      sigCode      <= '0;
      healthy      <= 1'b1;
      groupValid   <= 1'b0;
      groupPhase   <= PH_NONE;
      groupEven    <= 1'b0;
      unknownFault <= 1'b0;
    end else if (sampleValid) begin
      havePrev <= 1'b1;
      sigCode  <= sigNow;
      if (confirm) begin
        healthy      <= decHealthy;
        groupValid   <= decGroup;
        groupPhase   <= decPhase;
        groupEven    <= decEven;
        unknownFault <= decUnknown;
      end
    end
  end

  // R10
  one_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({healthy, groupValid, unknownFault}) == 1);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> $stable({sigCode, healthy, groupValid, groupPhase, groupEven, unknownFault}));

  // R7
  persist_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({healthy, groupValid, groupPhase, groupEven, unknownFault})
      |-> $past(sampleValid && (sigNow == prevSig)));

  // R4
  phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    groupValid |-> groupPhase != PH_NONE);

endmodule

// File: rtl/line_resid_classifier.sv
module line_resid_classifier
  import resid_pkg::*;
#(
  parameter int VW       = 16,
  parameter int UW       = 16,
  parameter int TH_MUL   = 26,
  parameter int TH_SHIFT = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleValid,
  input  logic signed [VW-1:0] measAb,
  input  logic signed [VW-1:0] measBc,
  input  logic signed [VW-1:0] measCa,
  input  logic signed [VW-1:0] cmdAb,
  input  logic signed [VW-1:0] cmdBc,
  input  logic signed [VW-1:0] cmdCa,
  input  logic [UW-1:0]        busV,
  output logic [5:0]           sigCode,
  output logic                 healthy,
  output logic                 groupValid,
  output logic [1:0]           groupPhase,
  output logic                 groupEven,
  output logic                 unknownFault
);

  dp_strobe_t          strobe;
  logic [SIG_W-1:0]    sigNow;
  logic [SIG_W-1:0]    prevSig;

  resid_datapath #(
    .VW(VW), .UW(UW), .TH_MUL(TH_MUL), .TH_SHIFT(TH_SHIFT)
  ) datapath_i (
    .clk     (clk),
    .rstN    (rstN),
    .measV   ({measAb, measBc, measCa}),
    .cmdV    ({cmdAb, cmdBc, cmdCa}),
    .busV    (busV),
    .strobe  (strobe),
    .sigNow  (sigNow),
    .prevSig (prevSig)
  );

  resid_control control_i (
    .clk          (clk),
    .rstN         (rstN),
    .sampleValid  (sampleValid),
    .sigNow       (sigNow),
    .prevSig      (prevSig),
    .strobe       (strobe),
    .sigCode      (sigCode),
    .healthy      (healthy),
    .groupValid   (groupValid),
    .groupPhase   (groupPhase),
    .groupEven    (groupEven),
    .unknownFault (unknownFault)
  );

endmodule

// File: tb/line_resid_classifier_tb_top.sv
module line_resid_classifier_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [15:0] measAb = '0, measBc = '0, measCa = '0;
  logic signed [15:0] cmdAb = '0, cmdBc = '0, cmdCa = '0;
  logic [15:0] busV = 16'd1000;
  logic [5:0]  sigCode;
  logic healthy, groupValid, groupEven, unknownFault;
  logic [1:0] groupPhase;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // reference model state
  logic [5:0] mPrev = '0;
  bit  mHave = 1'b0;
  int  eHealthy = 1, eGroup = 0, ePhase = 3, eEven = 0, eUnk = 0;
  logic [5:0] eSig = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_resid_classifier dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .measAb(measAb), .measBc(measBc), .measCa(measCa),
    .cmdAb(cmdAb), .cmdBc(cmdBc), .cmdCa(cmdCa),
    .busV(busV), .sigCode(sigCode), .healthy(healthy),
    .groupValid(groupValid), .groupPhase(groupPhase),
    .groupEven(groupEven), .unknownFault(unknownFault)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] tern(input int r, input int th);
    if (r > th) return 2'b01;
    if (r < -th) return 2'b11;
    return 2'b00;
  endfunction

  task automatic modelDecode(input logic [5:0] s);
    eHealthy = 0; eGroup = 1; eUnk = 0; eEven = 0; ePhase = 3;
    case (s)
      6'b000000: begin eHealthy = 1; eGroup = 0; end
      6'b110001: ePhase = 0;
      6'b010011: begin ePhase = 0; eEven = 1; end
      6'b011100: ePhase = 1;
      6'b110100: begin ePhase = 1; eEven = 1; end
      6'b000101: ePhase = 2;
      6'b001111: begin ePhase = 2; eEven = 1; end
      default:   begin eGroup = 0; eUnk = 1; end
    endcase
  endtask

  task automatic checkState(input string tag);
    chk({tag, " sigCode"}, int'(sigCode), int'(eSig));
    chk({tag, " healthy"}, int'(healthy), eHealthy);
    chk({tag, " groupValid"}, int'(groupValid), eGroup);
    chk({tag, " unknownFault"}, int'(unknownFault), eUnk);
    if (eGroup == 1) begin
      chk({tag, " groupPhase"}, int'(groupPhase), ePhase);
      chk({tag, " groupEven"}, int'(groupEven), eEven);
    end
  endtask

  // one valid sample with given residuals; commanded values vary with base
  task automatic sample(input int rAb, input int rBc, input int rCa,
                        input int bus, input int base, input string tag);
    int th;
    logic [5:0] s;
    @(negedge clk);
    cmdAb = 16'(base); cmdBc = 16'(-base); cmdCa = 16'(base / 2);
    measAb = 16'(base + rAb); measBc = 16'(-base + rBc); measCa = 16'(base / 2 + rCa);
    busV = 16'(bus);
    sampleValid = 1'b1;
    th = (bus * 26) / 256;
    s = {tern(rAb, th), tern(rBc, th), tern(rCa, th)};
    if (mHave && s == mPrev) modelDecode(s);
    mHave = 1'b1;
    mPrev = s;
    eSig = s;
    @(negedge clk);
    sampleValid = 1'b0;
    checkState(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    checkState("R9 reset");
  endtask

  task automatic testThreshold();
    // R1 R2: bus 1000 -> threshold 101
    sample(101, -101, 0, 1000, 200, "R1 at threshold");
    chk("R1 equal gives zero", int'(sigCode), 0);
    sample(102, -102, 0, 1000, -300, "R1 beyond threshold");
    chk("R1 R3 AB+ BC-", int'(sigCode), 6'b011100);
    // R2: bus 60000 -> threshold 6093
    sample(0, 6093, -6094, 60000, 50, "R2 high bus");
    chk("R2 high bus codes", int'(sigCode), 6'b000011);
    sample(6094, 0, -6093, 60000, 1234, "R2 high bus edge");
    chk("R2 R3 AB+ only", int'(sigCode), 6'b010000);
  endtask

  task automatic groupPair(input int a, input int b, input int c, input string tag);
    sample(a, b, c, 1000, 500, {tag, " first R7"});
    sample(a, b, c, 1000, -700, {tag, " second R4"});
  endtask

  task automatic testGroups();
    groupPair(-300, 0, 300, "A odd");
    groupPair(300, 0, -300, "A even");
    groupPair(300, -300, 0, "B odd");
    groupPair(-300, 300, 0, "B even");
    groupPair(0, 300, 300, "C odd");
    groupPair(0, -300, -300, "C even");
  endtask

  task automatic testUnknownAndHealthy();
    groupPair(300, 300, 300, "R6 unknown");
    chk("R6 unknownFault set", int'(unknownFault), 1);
    groupPair(10, -20, 5, "R5 healthy");
    chk("R5 healthy set", int'(healthy), 1);
  endtask

  task automatic testPersist();
    // alternating signatures never confirm
    sample(-300, 0, 300, 1000, 0, "R7 alt1");
    sample(300, -300, 0, 1000, 0, "R7 alt2");
    sample(-300, 0, 300, 1000, 0, "R7 alt3");
    chk("R7 alternation keeps healthy", int'(healthy), 1);
    // gap of idle cycles does not break a pair
    sample(0, -300, -300, 1000, 100, "R7 gap first");
    idle(4);
    sample(0, -300, -300, 1000, 900, "R7 gap second");
    chk("R7 confirmed across gap", int'(groupValid), 1);
  endtask

  task automatic testHold();
    logic [5:0] s0;
    s0 = sigCode;
    @(negedge clk);
    measAb = 16'sd5000; measBc = -16'sd5000; measCa = 16'sd3000;
    cmdAb = '0; cmdBc = '0; cmdCa = '0; busV = 16'd10;
    idle(5);
    chk("R8 sigCode held", int'(sigCode), int'(s0));
    checkState("R8 hold");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testThreshold();
    testGroups();
    testUnknownAndHealthy();
    testPersist();
    testHold();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule